// File: doc/BRIEF.md
# Shift-Register Stack Arithmetic Unit

This block is a zero-address arithmetic engine. Its operand storage is a stack made of registers. The top entry always lives in the same physical register. Every push moves each older entry one slot deeper, and every pop or add moves the entries one slot back toward the top. A caller issues one command per clock under a valid strobe. The commands are:

- push an immediate value,
- pop the top entry,
- add the two topmost entries and leave their sum on top.

The top entry is always visible on an output port. Overflow and underflow are each reported through a sticky flag. Both flags stay set until a synchronous clear input is raised.

The stack depth and the data width are parameters. The sum wraps within the data width and there is no carry output. An asynchronous active-low reset empties the stack and clears both flags. The reset is released synchronously inside the block.

Top module: `lifo_calc`

## Requirements
- R1: While reset is held, and after it is released, the top output reads zero, both error flags are low and the stack is empty.
- R2: A push on a stack with free room places `cmd_data` on the top output after the clock edge. Each older entry moves one slot deeper, so later pops return the values in last-in, first-out order.
- R3: A push on a full stack (DEPTH entries) sets the overflow flag. It leaves every stored entry and the occupancy unchanged.
- R4: A pop on a non-empty stack moves the second entry onto the top output. A pop on an empty stack sets the underflow flag and changes nothing.
- R5: An add with two or more entries replaces the top two entries with their sum modulo 2^WIDTH. It lowers the occupancy by exactly one, and each deeper entry moves up one slot.
- R6: An add with fewer than two entries sets the underflow flag and leaves the stack unchanged.
- R7: Each error flag stays set until `err_clr` is high at a clock edge. If a new error of the same kind happens in the same cycle as the clear, the flag stays set.
- R8: When `cmd_valid` is low, or the op code is 00, the stack does not change. The op codes are 00 none, 01 push, 10 pop and 11 add.
- R9: A slot that becomes vacant is cleared, so an empty stack shows zero on the top output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | Op code: 00 none, 01 push, 10 pop, 11 add |
| cmd_data | input | WIDTH | Immediate value for push |
| err_clr | input | 1 | Synchronous clear of both error flags |
| tos_data | output | WIDTH | Current top-of-stack value, zero when empty |
| ovf_err | output | 1 | Sticky overflow flag |
| unf_err | output | 1 | Sticky underflow flag |

## Verification
The bench fills the stack to capacity and then pushes once more. A design that shifted on that push would lose its bottom entry, and the pops that follow would return the wrong sequence.

It issues adds on empty and single-entry stacks. An implementation that checked only for emptiness would sum against a cleared slot and lower the occupancy.

Two large operands are added so that the sum must wrap. A clear is also issued in the same cycle as a fresh error, to catch a design that lets the clear win.

A long mixed command stream, including idle cycles that carry data, is then checked against a queue model on every clock. This exposes any mistake in the shift direction or in clearing the vacated slot.

// File: rtl/lifo_calc_pkg.sv
package lifo_calc_pkg;

  // Command encoding seen at the cmd_op port
  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_PUSH = 2'b01,
    OP_POP  = 2'b10,
    OP_ADD  = 2'b11
  } op_e;

  // Movement applied to the register column in one cycle
  typedef enum logic [1:0] {
    MV_HOLD = 2'b00,
    MV_DOWN = 2'b01,  // push: all entries one slot deeper
    MV_UP   = 2'b10,  // pop: all entries one slot toward the top
    MV_FOLD = 2'b11   // add: top takes the sum, the rest move up
  } move_e;

endpackage

// File: rtl/lifo_calc_rstsync.sv
module lifo_calc_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/lifo_calc_ctrl.sv
module lifo_calc_ctrl
  import lifo_calc_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  input  logic          err_clr,
  output move_e         move,
  output logic [CW-1:0] occ,
  output logic          ovf_err,
  output logic          unf_err
);

  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [CW-1:0] TWO_CNT  = CW'(2);

  logic [CW-1:0] occ_q, occ_d;
  logic          ovf_q, ovf_d;
  logic          unf_q, unf_d;
  logic          ovf_set, unf_set;
  logic          upd_en;
  op_e           op;

  assign op = op_e'(cmd_op);

  // Decode the command against the current occupancy
  always_comb begin
    move    = MV_HOLD;
    occ_d   = occ_q;
    ovf_set = 1'b0;
    unf_set = 1'b0;
    if (cmd_valid) begin
      unique case (op)
        OP_PUSH: begin
          if (occ_q == FULL_CNT) begin
            ovf_set = 1'b1;
          end else begin
            move  = MV_DOWN;
            occ_d = occ_q + 1'b1;
          end
        end
        OP_POP: begin
          if (occ_q == '0) begin
            unf_set = 1'b1;
          end else begin
            move  = MV_UP;
            occ_d = occ_q - 1'b1;
          end
        end
        OP_ADD: begin
          if (occ_q < TWO_CNT) begin
            unf_set = 1'b1;
          end else begin
            move  = MV_FOLD;
            occ_d = occ_q - 1'b1;
          end
        end
        default: begin
          move = MV_HOLD;
        end
      endcase
    end
  end

  // A new error has priority over the clear
  always_comb begin
    ovf_d = ovf_set | (ovf_q & ~err_clr);
    unf_d = unf_set | (unf_q & ~err_clr);
  end

  assign upd_en = cmd_valid | err_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_q <= '0;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else if (upd_en) begin
      occ_q <= occ_d;
      ovf_q <= ovf_d;
      unf_q <= unf_d;
    end
  end

  assign occ     = occ_q;
  assign ovf_err = ovf_q;
  assign unf_err = unf_q;

endmodule

// File: rtl/lifo_calc_add.sv
module lifo_calc_add #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  output logic [WIDTH-1:0] sum
);

  // Carry out of the top bit is dropped: the result wraps
  always_comb begin
    sum = opa + opb;
  end

endmodule

// File: rtl/lifo_calc_regs.sv
module lifo_calc_regs
  import lifo_calc_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  move_e            move,
  input  logic [WIDTH-1:0] push_val,
  input  logic [WIDTH-1:0] fold_val,
  output logic [WIDTH-1:0] top_val,
  output logic [WIDTH-1:0] next_val
);

  localparam int LAST = DEPTH - 1;

  logic [WIDTH-1:0] ent_q [DEPTH];
  logic [WIDTH-1:0] ent_d [DEPTH];
  logic             shift_en;

  assign shift_en = (move != MV_HOLD);

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    if (i == 0) begin : g_top
      always_comb begin
        unique case (move)
          MV_DOWN: ent_d[i] = push_val;
          MV_UP:   ent_d[i] = ent_q[i+1];
          MV_FOLD: ent_d[i] = fold_val;
          default: ent_d[i] = ent_q[i];
        endcase
      end
    end else if (i == LAST) begin : g_bottom
      // The bottom slot is cleared whenever the column moves up
      always_comb begin
        unique case (move)
          MV_DOWN: ent_d[i] = ent_q[i-1];
          MV_UP,
          MV_FOLD: ent_d[i] = '0;
          default: ent_d[i] = ent_q[i];
        endcase
      end
    end else begin : g_mid
      always_comb begin
        unique case (move)
          MV_DOWN: ent_d[i] = ent_q[i-1];
          MV_UP,
          MV_FOLD: ent_d[i] = ent_q[i+1];
          default: ent_d[i] = ent_q[i];
        endcase
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q[i] <= '0;
      end else if (shift_en) begin
        ent_q[i] <= ent_d[i];
      end
    end
  end

  assign top_val  = ent_q[0];
  assign next_val = ent_q[1];

endmodule

// File: rtl/lifo_calc.sv
module lifo_calc
  import lifo_calc_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [WIDTH-1:0] cmd_data,
  input  logic             err_clr,
  output logic [WIDTH-1:0] tos_data,
  output logic             ovf_err,
  output logic             unf_err
);

  localparam int CW = $clog2(DEPTH + 1);

  logic             rst_sync_n;
  move_e            move;
  logic [CW-1:0]    occ;
  logic [WIDTH-1:0] top_val, next_val, sum_val;

  lifo_calc_rstsync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  lifo_calc_ctrl #(.DEPTH(DEPTH), .CW(CW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .err_clr   (err_clr),
    .move      (move),
    .occ       (occ),
    .ovf_err   (ovf_err),
    .unf_err   (unf_err)
  );

  lifo_calc_add #(.WIDTH(WIDTH)) u_add (
    .opa (top_val),
    .opb (next_val),
    .sum (sum_val)
  );

  lifo_calc_regs #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .move     (move),
    .push_val (cmd_data),
    .fold_val (sum_val),
    .top_val  (top_val),
    .next_val (next_val)
  );

  assign tos_data = top_val;

endmodule

// File: rtl/lifo_calc_chk.sv
module lifo_calc_chk #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 8,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic [1:0]       cmd_op,
  input logic [WIDTH-1:0] cmd_data,
  input logic             err_clr,
  input logic [WIDTH-1:0] tos_data,
  input logic             ovf_err,
  input logic             unf_err,
  input logic [CW-1:0]    occ
);

  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [CW-1:0] TWO_CNT  = CW'(2);

  p_occ_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= FULL_CNT);

  p_push_top_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'b01 && occ != FULL_CNT) |=>
      (tos_data == $past(cmd_data)));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'b01 && occ == FULL_CNT) |=>
      (ovf_err && $stable(tos_data) && occ == FULL_CNT));

  p_pop_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'b10 && occ == '0) |=> (unf_err && occ == '0));

  p_add_shrink_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'b11 && occ >= TWO_CNT) |=>
      (occ == CW'($past(occ) - 1'b1)));

  p_add_short_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'b11 && occ < TWO_CNT) |=>
      (unf_err && $stable(occ) && $stable(tos_data)));

  p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_err && !err_clr) |=> ovf_err);

  p_unf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (unf_err && !err_clr) |=> unf_err);

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr && !cmd_valid) |=> (!ovf_err && !unf_err));

  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_valid && !err_clr) |=>
      ($stable(tos_data) && $stable(occ) && $stable(ovf_err) && $stable(unf_err)));

  p_empty_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == '0) |-> (tos_data == '0));

endmodule

bind lifo_calc lifo_calc_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .cmd_valid (cmd_valid),
  .cmd_op    (cmd_op),
  .cmd_data  (cmd_data),
  .err_clr   (err_clr),
  .tos_data  (tos_data),
  .ovf_err   (ovf_err),
  .unf_err   (unf_err),
  .occ       (occ)
);

// File: tb/lifo_calc_tb.sv
module lifo_calc_tb;

  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int D = 4;

  logic         clk;
  logic         rst_n;
  logic         cmd_valid;
  logic [1:0]   cmd_op;
  logic [W-1:0] cmd_data;
  logic         err_clr;
  logic [W-1:0] tos_data;
  logic         ovf_err;
  logic         unf_err;

  int checks;
  int errors;
  bit done;

  // Reference model: index 0 of the queue is the top of stack
  logic [W-1:0] mq[$];
  bit           m_ovf;
  bit           m_unf;

  lifo_calc #(.WIDTH(W), .DEPTH(D)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_data  (cmd_data),
    .err_clr   (err_clr),
    .tos_data  (tos_data),
    .ovf_err   (ovf_err),
    .unf_err   (unf_err)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  function automatic logic [W-1:0] model_top();
    return (mq.size() == 0) ? '0 : mq[0];
  endfunction

  task automatic compare(input string req);
    logic [W-1:0] et;
    et = model_top();
    checks++;
    if (tos_data !== et || ovf_err !== m_ovf || unf_err !== m_unf) begin
      errors++;
      $display("FAIL %s: tos=%0d ovf=%0b unf=%0b, expected tos=%0d ovf=%0b unf=%0b",
               req, tos_data, ovf_err, unf_err, et, m_ovf, m_unf);
    end
  endtask

  // Apply one command for one clock, update the model, compare after the edge
  task automatic step(input bit v, input logic [1:0] op,
                      input logic [W-1:0] d, input bit clr, input string req);
    bit so, su;
    logic [W-1:0] a, b;
    @(negedge clk);
    cmd_valid = v;
    cmd_op    = op;
    cmd_data  = d;
    err_clr   = clr;
    @(posedge clk);
    so = 0;
    su = 0;
    if (v) begin
      case (op)
        2'b01: if (mq.size() == D) so = 1; else mq.push_front(d);
        2'b10: if (mq.size() == 0) su = 1; else void'(mq.pop_front());
        2'b11: begin
          if (mq.size() < 2) su = 1;
          else begin
            a = mq.pop_front();
            b = mq.pop_front();
            mq.push_front(W'(a + b));
          end
        end
        default: ;
      endcase
    end
    m_ovf = so || (m_ovf && !clr);
    m_unf = su || (m_unf && !clr);
    #1;
    compare(req);
  endtask

  function automatic string tag_for(input bit v, input logic [1:0] op);
    if (!v || op == 2'b00) return "R8";
    if (op == 2'b01) return (mq.size() == D) ? "R3" : "R2";
    if (op == 2'b10) return (mq.size() == 0) ? "R4" : "R4";
    return (mq.size() < 2) ? "R6" : "R5";
  endfunction

  initial begin
    checks = 0;
    errors = 0;
    done = 0;
    m_ovf = 0;
    m_unf = 0;
    rst_n = 1'b0;
    cmd_valid = 1'b0;
    cmd_op = 2'b00;
    cmd_data = '0;
    err_clr = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    compare("R1 in reset");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    compare("R1 after release");

    // Underflow on empty pop and empty add
    step(1, 2'b10, 8'd0, 0, "R4 pop empty");
    step(0, 2'b00, 8'd0, 1, "R7 clear");
    step(1, 2'b11, 8'd0, 0, "R6 add empty");
    step(0, 2'b00, 8'd0, 0, "R7 flag holds");
    step(0, 2'b00, 8'd0, 1, "R7 clear");
    step(1, 2'b01, 8'd7, 0, "R2 push 7");
    step(1, 2'b11, 8'd0, 0, "R6 add one entry");
    step(1, 2'b10, 8'd0, 1, "R7 clear with pop");
    // Fill to capacity, then overflow
    step(1, 2'b01, 8'd11, 0, "R2 push");
    step(1, 2'b01, 8'd22, 0, "R2 push");
    step(1, 2'b01, 8'd33, 0, "R2 push");
    step(1, 2'b01, 8'd44, 0, "R2 push full");
    step(1, 2'b01, 8'd99, 0, "R3 push on full");
    step(0, 2'b01, 8'd55, 0, "R8 invalid push");
    step(1, 2'b00, 8'd66, 0, "R8 op none");
    // Clear in the same cycle as a fresh overflow keeps the flag
    step(1, 2'b01, 8'd77, 1, "R7 set beats clear");
    step(0, 2'b00, 8'd0, 1, "R7 clear");
    // LIFO drain shows nothing was corrupted by the overflow
    step(1, 2'b10, 8'd0, 0, "R4 pop");
    step(1, 2'b10, 8'd0, 0, "R4 pop");
    step(1, 2'b10, 8'd0, 0, "R4 pop");
    step(1, 2'b10, 8'd0, 0, "R9 pop last");
    // Wrapping add with a deeper entry moving up
    step(1, 2'b01, 8'd5, 0, "R2 push");
    step(1, 2'b01, 8'd200, 0, "R2 push");
    step(1, 2'b01, 8'd100, 0, "R2 push");
    step(1, 2'b11, 8'd0, 0, "R5 wrap add");
    step(1, 2'b11, 8'd0, 0, "R5 add deeper");
    step(1, 2'b10, 8'd0, 0, "R9 empty after add");

    // Mixed stream compared on every clock
    for (int k = 0; k < 400; k++) begin
      bit v;
      logic [1:0] op;
      logic [W-1:0] d;
      bit c;
      v  = ($urandom_range(0, 7) != 0);
      op = 2'($urandom_range(0, 3));
      d  = W'($urandom);
      c  = ($urandom_range(0, 9) == 0);
      step(v, op, d, c, tag_for(v, op));
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule